// File: doc/BRIEF.md
# Segment Base Relocation Unit

This block sits on the address path between a processor core and its shared hub memory. It relocates each hub access in hardware. A small register file holds three segment bases: code, data and stack/spare. Each base has a matching limit register. Software sets and reads these registers through a selector-addressed port, which is driven by set-segment and get-segment operations.

On every access the block adds one segment base to the untranslated offset. Before the add, the base is shifted left by four bits, so bases fall on 16-byte paragraph boundaries. Which base is used depends on the access:

- Instruction fetches use the code base.
- Data accesses with the alternate flag clear use the data base.
- Data accesses with the alternate flag set use the stack base.

A zero base leaves the address untouched. Because all registers reset to zero, software that knows nothing about relocation still sees flat memory.

A nonzero limit bounds the offset. When the offset reaches or passes the limit, the block raises a violation flag that a later trap stage can use. Translation is purely combinational. Register writes take effect at the rising clock edge.

Top module: `seg_reloc_unit`

## Requirements
- R1: After reset every base and limit register reads zero, and every access translates to its own offset (identity mapping).
- R2: An instruction fetch (`req_fetch_i`=1) adds the code base (selector 0) whatever the value of `req_alt_i`.
- R3: A data access (`req_fetch_i`=0) with `req_alt_i`=0 adds the data base (selector 1).
- R4: A data access with `req_alt_i`=1 adds the stack base (selector 2).
- R5: The translated address is offset + (base << 4), taken modulo 2^ADDR_W.
- R6: Selector n+4 (4, 5, 6) reaches the limit register paired with segment n (0, 1, 2), and it reads back what was written.
- R7: With `req_valid_i`=1 and a nonzero limit L on the selected segment, `limit_viol_o` is 1 exactly when the untranslated offset is >= L*16.
- R8: A limit of zero never raises `limit_viol_o`.
- R9: Writes to selector 3 or 7 change nothing, and reads from those selectors return zero.
- R10: A register write becomes visible on the clock edge that follows it. An access in the same cycle as the write uses the old value.
- R11: `limit_viol_o` is 0 whenever `req_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Set-segment write strobe |
| reg_sel_i | input | 3 | Selector: bit 2 picks limit (1) or base (0), bits 1:0 pick the segment |
| reg_wdata_i | input | REG_W | Value to write |
| reg_rdata_o | output | REG_W | Get-segment read value for `reg_sel_i` |
| req_valid_i | input | 1 | An access is present |
| req_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| req_alt_i | input | 1 | Alternate flag for data accesses |
| req_addr_i | input | ADDR_W | Untranslated hub offset |
| xlat_addr_o | output | ADDR_W | Relocated hub address |
| limit_viol_o | output | 1 | Offset at or beyond the selected nonzero limit |

## Verification
The assertions assume that `reg_sel_i` and `reg_we_i` carry known values from reset onward. They also assume that any read-back comparison across an edge is meaningful only while the selector stays the same; the properties skip cycles where it changes. The stimulus changes inputs only at falling edges and holds them steady through each rising edge. Several writes go into registers that are being accessed in the same cycle, so the old-value and new-value windows can each be observed separately.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
  localparam int unsigned NUM_SEG    = 3;
  localparam int unsigned PARA_SHIFT = 4;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_RSVD  = 2'd3
  } seg_idx_e;
endpackage

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_reloc_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] base_o  [NUM_SEG],
  output logic [REG_W-1:0] limit_o [NUM_SEG]
);
  logic [REG_W-1:0] base_q  [NUM_SEG];
  logic [REG_W-1:0] limit_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic hit;
    assign hit = we_i && (sel_i[1:0] == g[1:0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
      end else if (hit) begin
        if (sel_i[2]) limit_q[g] <= wdata_i;
        else          base_q[g]  <= wdata_i;
      end
    end

    assign base_o[g]  = base_q[g];
    assign limit_o[g] = limit_q[g];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i[1:0] != SEG_RSVD) begin
      rdata_o = sel_i[2] ? limit_q[sel_i[1:0]] : base_q[sel_i[1:0]];
    end
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_reloc_pkg::*;
(
  input  logic     fetch_i,
  input  logic     alt_i,
  output seg_idx_e idx_o
);
  always_comb begin
    if (fetch_i)    idx_o = SEG_CODE;
    else if (alt_i) idx_o = SEG_STACK;
    else            idx_o = SEG_DATA;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_reloc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned REG_W  = 16
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] offs_i,
  input  logic [REG_W-1:0]  base_i,
  input  logic [REG_W-1:0]  limit_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              viol_o
);
  localparam int unsigned SH_W  = REG_W + PARA_SHIFT;
  localparam int unsigned CMP_W = (ADDR_W > SH_W) ? ADDR_W : SH_W;

  logic [CMP_W-1:0] base_sh, limit_sh, offs_ext, sum;

  assign base_sh  = CMP_W'({base_i,  {PARA_SHIFT{1'b0}}});
  assign limit_sh = CMP_W'({limit_i, {PARA_SHIFT{1'b0}}});
  assign offs_ext = CMP_W'(offs_i);
  assign sum      = offs_ext + base_sh;

  // wrap modulo hub width
  assign addr_o = sum[ADDR_W-1:0];
  assign viol_o = valid_i && (limit_i != '0) && (offs_ext >= limit_sh);
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
  import seg_reloc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              req_valid_i,
  input  logic              req_fetch_i,
  input  logic              req_alt_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [ADDR_W-1:0] xlat_addr_o,
  output logic              limit_viol_o
);
  logic [REG_W-1:0] base  [NUM_SEG];
  logic [REG_W-1:0] limit [NUM_SEG];
  seg_idx_e         idx;

  seg_reg_file #(.REG_W(REG_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base_o  (base),
    .limit_o (limit)
  );

  seg_select u_sel (
    .fetch_i (req_fetch_i),
    .alt_i   (req_alt_i),
    .idx_o   (idx)
  );

  seg_xlate #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_xlate (
    .valid_i (req_valid_i),
    .offs_i  (req_addr_i),
    .base_i  (base[idx]),
    .limit_i (limit[idx]),
    .addr_o  (xlat_addr_o),
    .viol_o  (limit_viol_o)
  );
endmodule

// File: rtl/seg_reloc_unit_chk.sv
module seg_reloc_unit_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned REG_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [2:0]        reg_sel_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              limit_viol_o
);
  p_idle_no_viol_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !limit_viol_o);

  p_rsvd_reads_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i[1:0] == 2'd3) |-> (reg_rdata_o == '0));

  p_write_visible_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i[1:0] != 2'd3) |=>
      ((reg_sel_i != $past(reg_sel_i)) || (reg_rdata_o == $past(reg_wdata_i))));

  p_hold_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> ((reg_sel_i != $past(reg_sel_i)) || $stable(reg_rdata_o)));

  // a nonzero limit is at least one paragraph
  p_viol_min_offset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_viol_o |-> (req_addr_i >= ADDR_W'(16)));
endmodule

bind seg_reloc_unit seg_reloc_unit_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_sel_i    (reg_sel_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .limit_viol_o (limit_viol_o)
);

// File: tb/seg_reloc_unit_test.sv
module seg_reloc_unit_test;
  localparam int ADDR_W = 20;
  localparam int REG_W  = 16;
  localparam int NV     = 16;

  typedef struct packed {
    logic              we;
    logic [2:0]        sel;
    logic [REG_W-1:0]  wdata;
    logic              valid;
    logic              fetch;
    logic              alt;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] exp_addr;
    logic              exp_viol;
    logic [7:0]        rq;
  } vec_t;

  // we sel wdata valid fetch alt addr exp_addr exp_viol req
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd1, 16'h0010, 1'b1, 1'b0, 1'b0, 20'h00100, 20'h00100, 1'b0, 8'd10}, // R10 old base
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 20'h00100, 20'h00200, 1'b0, 8'd3},  // R3
    '{1'b1, 3'd0, 16'h0200, 1'b1, 1'b1, 1'b1, 20'h00050, 20'h00050, 1'b0, 8'd10},
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b1, 20'h00050, 20'h02050, 1'b0, 8'd2},  // R2 alt ignored
    '{1'b1, 3'd2, 16'h0F00, 1'b1, 1'b0, 1'b1, 20'h00004, 20'h00004, 1'b0, 8'd10},
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 1'b1, 20'h00004, 20'h0F004, 1'b0, 8'd4},  // R4
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b0, 20'h00001, 20'h02001, 1'b0, 8'd2},
    '{1'b1, 3'd1, 16'hFFFF, 1'b1, 1'b0, 1'b0, 20'h00010, 20'h00110, 1'b0, 8'd10},
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 20'h00020, 20'h00010, 1'b0, 8'd5},  // R5 wrap
    '{1'b1, 3'd5, 16'h0002, 1'b1, 1'b0, 1'b0, 20'h0001F, 20'h0000F, 1'b0, 8'd6},
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 20'h00020, 20'h00010, 1'b1, 8'd7},  // R7 at limit
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 20'h0001F, 20'h0000F, 1'b0, 8'd7},  // R7 below
    '{1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 20'h00040, 20'h00030, 1'b0, 8'd11}, // R11
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b0, 20'h00040, 20'h02040, 1'b0, 8'd8},  // R8 code
    '{1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 1'b1, 20'h00040, 20'h0F040, 1'b0, 8'd8},  // R8 stack
    '{1'b1, 3'd3, 16'h1234, 1'b1, 1'b1, 1'b0, 20'h00000, 20'h02000, 1'b0, 8'd9}   // R9
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [2:0]        reg_sel_i = '0;
  logic [REG_W-1:0]  reg_wdata_i = '0;
  logic [REG_W-1:0]  reg_rdata_o;
  logic              req_valid_i = 1'b0;
  logic              req_fetch_i = 1'b0;
  logic              req_alt_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [ADDR_W-1:0] xlat_addr_o;
  logic              limit_viol_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  seg_reloc_unit #(.ADDR_W(ADDR_W), .REG_W(REG_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .req_valid_i(req_valid_i), .req_fetch_i(req_fetch_i), .req_alt_i(req_alt_i),
    .req_addr_i(req_addr_i), .xlat_addr_o(xlat_addr_o), .limit_viol_o(limit_viol_o)
  );

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic rd_chk(input logic [2:0] sel, input logic [REG_W-1:0] exp, input int rq);
    @(negedge clk);
    reg_we_i  = 1'b0;
    reg_sel_i = sel;
    #2 check(rq, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic wr(input logic [2:0] sel, input logic [REG_W-1:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    for (int s = 0; s < 8; s++) rd_chk(3'(s), '0, 1);
    @(negedge clk);
    req_valid_i = 1'b1; req_fetch_i = 1'b0; req_alt_i = 1'b1; req_addr_i = 20'h12345;
    #2 check(1, 32'(xlat_addr_o), 32'h12345);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_we_i    = VECS[i].we;
      reg_sel_i   = VECS[i].sel;
      reg_wdata_i = VECS[i].wdata;
      req_valid_i = VECS[i].valid;
      req_fetch_i = VECS[i].fetch;
      req_alt_i   = VECS[i].alt;
      req_addr_i  = VECS[i].addr;
      #2;
      check(int'(VECS[i].rq), 32'(xlat_addr_o), 32'(VECS[i].exp_addr));
      check(int'(VECS[i].rq), 32'(limit_viol_o), 32'(VECS[i].exp_viol));
    end

    // R6, R9, R10 readback
    rd_chk(3'd0, 16'h0200, 10);
    rd_chk(3'd1, 16'hFFFF, 10);
    rd_chk(3'd2, 16'h0F00, 10);
    rd_chk(3'd5, 16'h0002, 6);
    rd_chk(3'd3, 16'h0000, 9);
    wr(3'd7, 16'hABCD);
    rd_chk(3'd7, 16'h0000, 9);
    wr(3'd6, 16'h0001);
    rd_chk(3'd6, 16'h0001, 6);
    rd_chk(3'd4, 16'h0000, 6);
    // R6: stack limit 16 bytes
    @(negedge clk);
    req_valid_i = 1'b1; req_fetch_i = 1'b0; req_alt_i = 1'b1; req_addr_i = 20'h00010;
    #2 check(6, 32'(limit_viol_o), 32'd1);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    rd_chk(3'd0, '0, 1);
    rd_chk(3'd5, '0, 1);
    @(negedge clk);
    req_valid_i = 1'b1; req_fetch_i = 1'b1; req_alt_i = 1'b0; req_addr_i = 20'h00777;
    #2 check(1, 32'(xlat_addr_o), 32'h00777);
    req_fetch_i = 1'b0; req_addr_i = 20'h00020;
    #1 check(1, 32'(limit_viol_o), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule